// File: doc/BRIEF.md
# Serial Port with Parity on an AHB-Lite Slave

This block is a serial transmitter and receiver on an AHB-Lite slave port. Every character on the line is an 11-bit frame. The frame holds a low start bit, eight data bits, one parity bit and a high stop bit. The parity bit is produced by a separate generator unit and judged by a separate checker unit, so the two shift registers only move nine payload bits and never compute parity themselves. A configuration input selects even or odd parity. Two fault-injection inputs corrupt parity on purpose: one inverts the transmitted parity bit, the other forces the checker to report an error.

Software reaches the block through one data port and one status word. A bus write to the data offset queues a byte for transmission. A bus write to any other offset reprograms the baud divisor. A bus read of the data offset takes the oldest received byte. A bus read of the status offset returns the FIFO flags, a sticky parity-error flag and a saturating count of bad frames. Each bad frame also raises `parity_err` for one clock.

Top module: `ahb_parity_uart`

## Requirements
- R1: After reset `serial_tx` is high, `parity_err` is low, `hreadyout` is high and a status read returns zero.
- R2: A frame on `serial_tx` is a low start bit, then data bits 0 through 7 (least significant first), then the parity bit, then a high stop bit. From the second frame bit onward, each bit lasts 16*(D+1) clocks, where D is the programmed divisor.
- R3: With `cfg_odd`=0 the parity bit equals the XOR of the eight data bits. With `cfg_odd`=1 it is the inverse of that XOR.
- R4: A write whose `haddr[3:0]` is 0 queues `hwdata[7:0]` for transmission. A write with any nonzero `haddr[3:0]` loads `hwdata[15:0]` as the divisor. The write data is taken in the cycle after the address phase.
- R5: A read at `haddr[3:0]`=0 returns the oldest received byte in `hrdata[7:0]` and removes it. A read at `haddr[3:0]`=4 returns status: bit 0 is TX FIFO full, bit 1 is RX FIFO not empty, bit 2 is the sticky parity error, and bits 15:8 are the error count.
- R6: The receiver samples `serial_rx` at 16 times the tick rate, at mid-bit. A low pulse that has ended before the middle of the start bit yields no frame.
- R7: With `cfg_inject_tx`=1 the transmitted parity bit is inverted, and the receiver reports that frame as bad while still storing its data byte.
- R8: With `cfg_inject_rx`=1 every received frame is reported as bad, even when its parity is correct.
- R9: Each bad frame raises `parity_err` for exactly one clock and sets status bit 2, which stays set until reset.
- R10: Status bits 15:8 count bad frames since reset and hold at 255.
- R11: The TX FIFO holds 16 bytes. Status bit 0 reads 1 when it is full, and a write to a full TX FIFO is dropped.
- R12: The RX FIFO holds 16 bytes. A frame that arrives while it is full is discarded, but its parity is still checked and counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Clock |
| hresetn | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select |
| haddr | input | 4 | Byte offset within the block |
| htrans | input | 2 | Transfer type; bit 1 marks an active transfer |
| hwrite | input | 1 | Write when high, read when low |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready | input | 1 | Bus ready; an address phase is taken when high |
| hrdata | output | 32 | Read data, valid in the data phase |
| hreadyout | output | 1 | Always high: no wait states |
| cfg_odd | input | 1 | 0 selects even parity, 1 selects odd parity |
| cfg_inject_tx | input | 1 | Inverts the transmitted parity bit |
| cfg_inject_rx | input | 1 | Forces the checker to flag every received frame |
| serial_rx | input | 1 | Serial input line |
| serial_tx | output | 1 | Serial output line, idle high |
| parity_err | output | 1 | One-clock pulse per bad received frame |

## Verification
Two things can happen in the same receive cycle: a frame completes while the RX FIFO is already full, and that frame has a parity error. The discard path and the error accounting then act together. The bench provokes this by looping `serial_tx` back to `serial_rx` with transmit-side injection enabled. It streams 256 frames and never reads, so sixteen bytes fill the RX FIFO and every later frame arrives at a full FIFO. It then judges three results: the count stops at 255, one `parity_err` pulse is seen per frame, and exactly the first sixteen bytes come back in order.

// File: rtl/upar_pkg.sv
package upar_pkg;
   localparam int CHAR_W   = 8;
   localparam int FRAME_W  = CHAR_W + 1;
   localparam int OVS      = 16;
   localparam int ST_TXFUL = 0;
   localparam int ST_RXAV  = 1;
   localparam int ST_PERR  = 2;
   localparam int ST_CNT   = 8;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_BITS,
      RX_STOP
   } rx_state_e;
endpackage

// File: rtl/upar_fifo.sv
module upar_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             full,
   output logic             empty
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("upar_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW:0]      wptr, rptr;
   logic [AW:0]      level;
   logic             do_push, do_pop;

   assign full    = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
   assign empty   = (wptr == rptr);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign level   = wptr - rptr;
   assign rdata   = mem[rptr[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr[AW-1:0]] <= wdata;
   end

   assert_level_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      int'(level) <= DEPTH);
   assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> full);
   assert_full_empty_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));
endmodule

// File: rtl/upar_parity.sv
module upar_parity #(
   parameter bit CHECKER = 1'b0,
   parameter int DATA_W  = 8
) (
   input  logic [DATA_W-1:0] data,
   input  logic              odd,
   input  logic              inject,
   input  logic              rx_par,
   output logic              out
);
   logic expect_bit;
   assign expect_bit = (^data) ^ odd;

   if (CHECKER) begin : g_check
      assign out = (expect_bit != rx_par) | inject;
   end else begin : g_gen
      logic unused_rx_par;
      assign unused_rx_par = rx_par;
      assign out = expect_bit ^ inject;
   end
endmodule

// File: rtl/upar_tx.sv
module upar_tx #(
   parameter int FRAME_W = 9,
   parameter int OVS     = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   output logic               busy,
   output logic               txd
);
   localparam int SH_W = FRAME_W + 2;
   localparam int OW   = $clog2(OVS);
   localparam int BW   = $clog2(SH_W + 1);

   if (OVS < 4) begin : g_bad_ovs
      $error("upar_tx: OVS must be at least 4");
   end

   logic [SH_W-1:0] sh;
   logic [OW-1:0]   tcnt;
   logic [BW-1:0]   left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sh   <= '1;
         tcnt <= '0;
         left <= '0;
      end else if (load && !busy) begin
         busy <= 1'b1;
         sh   <= {1'b1, frame, 1'b0};
         tcnt <= '0;
         left <= BW'(SH_W);
      end else if (busy && tick) begin
         if (tcnt == OW'(OVS - 1)) begin
            tcnt <= '0;
            sh   <= {1'b1, sh[SH_W-1:1]};
            left <= left - 1'b1;
            if (left == BW'(1)) busy <= 1'b0;
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end

   assign txd = sh[0];

   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);
   assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !busy) |=> (busy && !txd));
endmodule

// File: rtl/upar_rx.sv
module upar_rx
   import upar_pkg::*;
#(
   parameter int FRAME_W = 9,
   parameter int OVS     = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               rxd,
   output logic               valid,
   output logic [FRAME_W-1:0] frame
);
   localparam int OW = $clog2(OVS);
   localparam int BW = $clog2(FRAME_W);

   rx_state_e     state;
   logic [1:0]    sync;
   logic          rx_s;
   logic [OW-1:0] tcnt;
   logic [BW-1:0] bcnt;

   assign rx_s = sync[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync  <= 2'b11;
         state <= RX_IDLE;
         tcnt  <= '0;
         bcnt  <= '0;
         frame <= '0;
         valid <= 1'b0;
      end else begin
         sync  <= {sync[0], rxd};
         valid <= 1'b0;
         if (tick) begin
            unique case (state)
               RX_IDLE: begin
                  if (!rx_s) begin
                     state <= RX_START;
                     tcnt  <= '0;
                  end
               end
               RX_START: begin
                  if (tcnt == OW'(OVS / 2 - 1)) begin
                     tcnt  <= '0;
                     bcnt  <= '0;
                     state <= rx_s ? RX_IDLE : RX_BITS;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               RX_BITS: begin
                  if (tcnt == OW'(OVS - 1)) begin
                     tcnt  <= '0;
                     frame <= {rx_s, frame[FRAME_W-1:1]};
                     if (bcnt == BW'(FRAME_W - 1)) state <= RX_STOP;
                     else bcnt <= bcnt + 1'b1;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (tcnt == OW'(OVS - 1)) begin
                     tcnt  <= '0;
                     state <= RX_IDLE;
                     valid <= rx_s;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
   assert_valid_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (state == RX_IDLE && $past(state) == RX_STOP));
endmodule

// File: rtl/ahb_parity_uart.sv
module ahb_parity_uart
   import upar_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int BUS_W       = 32,
   parameter int FIFO_DEPTH  = 16,
   parameter int DIV_W       = 16,
   parameter int DEFAULT_DIV = 3,
   parameter int CNT_W       = 8,
   parameter int STAT_OFS    = 4
) (
   input  logic              hclk,
   input  logic              hresetn,
   input  logic              hsel,
   input  logic [ADDR_W-1:0] haddr,
   input  logic [1:0]        htrans,
   input  logic              hwrite,
   input  logic [BUS_W-1:0]  hwdata,
   input  logic              hready,
   output logic [BUS_W-1:0]  hrdata,
   output logic              hreadyout,
   input  logic              cfg_odd,
   input  logic              cfg_inject_tx,
   input  logic              cfg_inject_rx,
   input  logic              serial_rx,
   output logic              serial_tx,
   output logic              parity_err
);
   if (DIV_W >= BUS_W || DIV_W < 1) begin : g_bad_div
      $error("ahb_parity_uart: DIV_W must be narrower than BUS_W");
   end
   if (ST_CNT + CNT_W > BUS_W) begin : g_bad_cnt
      $error("ahb_parity_uart: error counter does not fit the status word");
   end

   // bus decode: address phase registered, action in data phase
   logic              dp_act, dp_wr;
   logic [ADDR_W-1:0] dp_addr;
   logic              wr_tx, wr_div, rd_pop, rd_stat;

   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn) begin
         dp_act  <= 1'b0;
         dp_wr   <= 1'b0;
         dp_addr <= '0;
      end else if (hready) begin
         dp_act  <= hsel && htrans[1];
         dp_wr   <= hwrite;
         dp_addr <= haddr;
      end
   end

   assign wr_tx     = dp_act && dp_wr && (dp_addr == '0);
   assign wr_div    = dp_act && dp_wr && (dp_addr != '0);
   assign rd_pop    = dp_act && !dp_wr && (dp_addr == '0);
   assign rd_stat   = dp_act && !dp_wr && (dp_addr == ADDR_W'(STAT_OFS));
   assign hreadyout = 1'b1;

   logic unused_ok;
   assign unused_ok = &{1'b0, htrans[0], hwdata[BUS_W-1:DIV_W]};

   // baud tick: one tick every divisor+1 clocks
   logic [DIV_W-1:0] divisor, bcnt;
   logic             tick;

   assign tick = (bcnt >= divisor);

   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn) begin
         divisor <= DIV_W'(DEFAULT_DIV);
         bcnt    <= '0;
      end else begin
         if (wr_div) divisor <= hwdata[DIV_W-1:0];
         bcnt <= tick ? '0 : bcnt + 1'b1;
      end
   end

   // transmit path
   logic [CHAR_W-1:0] txf_head;
   logic              txf_full, txf_empty, tx_busy, tx_load, tx_par;

   assign tx_load = !txf_empty && !tx_busy;

   upar_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH)) u_txf (
      .clk(hclk), .rst_n(hresetn), .push(wr_tx), .wdata(hwdata[CHAR_W-1:0]),
      .pop(tx_load), .rdata(txf_head), .full(txf_full), .empty(txf_empty));

   upar_parity #(.CHECKER(1'b0), .DATA_W(CHAR_W)) u_pgen (
      .data(txf_head), .odd(cfg_odd), .inject(cfg_inject_tx),
      .rx_par(1'b0), .out(tx_par));

   upar_tx #(.FRAME_W(FRAME_W), .OVS(OVS)) u_tx (
      .clk(hclk), .rst_n(hresetn), .tick(tick), .load(tx_load),
      .frame({tx_par, txf_head}), .busy(tx_busy), .txd(serial_tx));

   // receive path
   logic               rx_valid, rx_bad;
   logic [FRAME_W-1:0] rx_frame;
   logic [CHAR_W-1:0]  rxf_head;
   logic               rxf_full, rxf_empty;

   upar_rx #(.FRAME_W(FRAME_W), .OVS(OVS)) u_rx (
      .clk(hclk), .rst_n(hresetn), .tick(tick), .rxd(serial_rx),
      .valid(rx_valid), .frame(rx_frame));

   upar_parity #(.CHECKER(1'b1), .DATA_W(CHAR_W)) u_pchk (
      .data(rx_frame[CHAR_W-1:0]), .odd(cfg_odd), .inject(cfg_inject_rx),
      .rx_par(rx_frame[CHAR_W]), .out(rx_bad));

   upar_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH)) u_rxf (
      .clk(hclk), .rst_n(hresetn), .push(rx_valid), .wdata(rx_frame[CHAR_W-1:0]),
      .pop(rd_pop), .rdata(rxf_head), .full(rxf_full), .empty(rxf_empty));

   // error accounting
   logic             sticky;
   logic [CNT_W-1:0] err_cnt;

   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn) begin
         parity_err <= 1'b0;
         sticky     <= 1'b0;
         err_cnt    <= '0;
      end else begin
         parity_err <= rx_valid && rx_bad;
         if (rx_valid && rx_bad) begin
            sticky <= 1'b1;
            if (err_cnt != '1) err_cnt <= err_cnt + 1'b1;
         end
      end
   end

   // read mux
   logic [BUS_W-1:0] status;
   always_comb begin
      status                   = '0;
      status[ST_TXFUL]         = txf_full;
      status[ST_RXAV]          = !rxf_empty;
      status[ST_PERR]          = sticky;
      status[ST_CNT +: CNT_W]  = err_cnt;
   end

   assign hrdata = rd_pop  ? BUS_W'(rxf_head) :
                   rd_stat ? status : '0;

   assert_cnt_saturate_R10: assert property (@(posedge hclk) disable iff (!hresetn)
      (err_cnt == '1) |=> (err_cnt == '1));
   assert_cnt_step_R10: assert property (@(posedge hclk) disable iff (!hresetn)
      (err_cnt != $past(err_cnt)) |-> (err_cnt == $past(err_cnt) + 1'b1));
   assert_pulse_counts_R9: assert property (@(posedge hclk) disable iff (!hresetn)
      (parity_err && $past(err_cnt) != '1) |-> (err_cnt == $past(err_cnt) + 1'b1));
   assert_sticky_holds_R9: assert property (@(posedge hclk) disable iff (!hresetn)
      sticky |=> sticky);
   assert_drop_when_full_R12: assert property (@(posedge hclk) disable iff (!hresetn)
      (rxf_full && rx_valid && !rd_pop) |=> rxf_full);
endmodule

// File: tb/ahb_parity_uart_tb.sv
module ahb_parity_uart_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        hsel, hwrite, hready;
   logic [3:0]  haddr;
   logic [1:0]  htrans;
   logic [31:0] hwdata, hrdata;
   logic        hreadyout;
   logic        cfg_odd, cfg_inject_tx, cfg_inject_rx;
   logic        serial_rx, serial_tx, parity_err;
   logic        loop_en, drv_rx;

   int n_checks = 0;
   int n_fail   = 0;
   int perr_seen = 0;
   int bit_p = 4;

   always #5 clk = ~clk;

   assign serial_rx = loop_en ? serial_tx : drv_rx;

   ahb_parity_uart u_dut (
      .hclk(clk), .hresetn(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
      .hwrite(hwrite), .hwdata(hwdata), .hready(hready), .hrdata(hrdata),
      .hreadyout(hreadyout), .cfg_odd(cfg_odd), .cfg_inject_tx(cfg_inject_tx),
      .cfg_inject_rx(cfg_inject_rx), .serial_rx(serial_rx), .serial_tx(serial_tx),
      .parity_err(parity_err));

   always @(negedge clk) if (rst_n && parity_err) perr_seen++;

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = a;
      @(negedge clk);
      hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hwdata = d;
      @(negedge clk);
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      hsel = 1'b1; htrans = 2'b10; hwrite = 1'b0; haddr = a;
      @(negedge clk);
      hsel = 1'b0; htrans = 2'b00;
      d = hrdata;
   endtask

   task automatic wait_rx(output bit got);
      logic [31:0] s;
      got = 1'b0;
      for (int k = 0; k < 3000; k++) begin
         bus_read(4'h4, s);
         if (s[1]) begin got = 1'b1; break; end
      end
   endtask

   task automatic get_frame(output logic [10:0] f);
      f = '1;
      for (int k = 0; k < 5000; k++) begin
         @(negedge clk);
         if (!serial_tx) break;
      end
      repeat (8 * bit_p) @(negedge clk);
      f[0] = serial_tx;
      for (int i = 1; i < 11; i++) begin
         repeat (16 * bit_p) @(negedge clk);
         f[i] = serial_tx;
      end
   endtask

   // send one byte over the loopback and judge line and received data
   task automatic send_check(input logic [7:0] b, input string req);
      logic [10:0] f;
      logic [31:0] d;
      logic        exp_par;
      bit          got;
      int          p0;
      p0 = perr_seen;
      exp_par = (^b) ^ cfg_odd ^ cfg_inject_tx;
      bus_write(4'h0, {24'h0, b});
      get_frame(f);
      chk(f[0] == 1'b0 && f[8:1] == b && f[10] == 1'b1, {req, "/R2 frame"}, f, {1'b1, exp_par, b, 1'b0});
      chk(f[9] == exp_par, {req, "/R3 parity bit"}, f[9], exp_par);
      wait_rx(got);
      bus_read(4'h0, d);
      chk(got && d[7:0] == b, {req, "/R5 rx byte"}, d, b);
      repeat (4) @(negedge clk);
      chk(perr_seen - p0 == ((cfg_inject_tx || cfg_inject_rx) ? 1 : 0), {req, "/R9 pulse"},
          perr_seen - p0, (cfg_inject_tx || cfg_inject_rx) ? 1 : 0);
   endtask

   initial begin
      logic [31:0] s, d;
      bit got;
      int len;
      rst_n = 1'b0; hsel = 1'b0; hwrite = 1'b0; hready = 1'b1; haddr = '0;
      htrans = '0; hwdata = '0; cfg_odd = 1'b0; cfg_inject_tx = 1'b0;
      cfg_inject_rx = 1'b0; loop_en = 1'b1; drv_rx = 1'b1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(serial_tx == 1'b1, "R1 serial_tx idle", serial_tx, 1);
      chk(parity_err == 1'b0 && hreadyout == 1'b1, "R1 outputs", {parity_err, hreadyout}, 2'b01);
      bus_read(4'h4, s);
      chk(s == 32'h0, "R1 status", s, 0);

      // R4/R2 divisor 2 -> bit time 48 clocks, byte 0x01 so data bit 0 is one high bit
      bus_write(4'h8, 32'd2);
      bit_p = 3;
      bus_write(4'h0, 32'h01);
      for (int k = 0; k < 5000; k++) begin @(negedge clk); if (!serial_tx) break; end
      for (int k = 0; k < 5000; k++) begin @(negedge clk); if (serial_tx) break; end
      len = 0;
      while (serial_tx && len < 1000) begin @(negedge clk); len++; end
      chk(len == 48, "R4 R2 bit time div2", len, 48);
      wait_rx(got);
      bus_read(4'h0, d);
      chk(got && d[7:0] == 8'h01, "R2 slow byte", d, 1);

      // R4 divisor 0 -> 16 clocks per bit
      bus_write(4'hC, 32'd0);
      bit_p = 1;

      // R3 even parity, full sweep of byte values
      for (int b = 0; b < 256; b++) send_check(8'(b), "R3 even");
      // R3 odd parity sweep
      cfg_odd = 1'b1;
      for (int i = 0; i < 32; i++) send_check(8'(i * 37 + 5), "R3 odd");
      cfg_odd = 1'b0;
      bus_read(4'h4, s);
      chk(s == 32'h0, "R10 no errors after clean sweep", s, 0);

      // R6 start glitch shorter than half a bit
      loop_en = 1'b0;
      @(negedge clk); drv_rx = 1'b0;
      repeat (4) @(negedge clk); drv_rx = 1'b1;
      repeat (400) @(negedge clk);
      bus_read(4'h4, s);
      chk(s[1] == 1'b0, "R6 glitch rejected", s[1], 0);
      loop_en = 1'b1;

      // R7 transmit-side injection
      cfg_inject_tx = 1'b1;
      for (int i = 0; i < 3; i++) send_check(8'(8'hA5 + i), "R7 inject tx");
      cfg_inject_tx = 1'b0;
      bus_read(4'h4, s);
      chk(s[15:8] == 8'd3 && s[2] == 1'b1, "R9 R10 count 3 sticky", s, 32'h0304);

      // R8 receive-side injection
      cfg_inject_rx = 1'b1;
      for (int i = 0; i < 2; i++) send_check(8'(8'h3C + i), "R8 inject rx");
      cfg_inject_rx = 1'b0;
      send_check(8'h77, "R8 injection off");
      bus_read(4'h4, s);
      chk(s[15:8] == 8'd5 && s[2] == 1'b1, "R9 R10 count 5 sticky", s, 32'h0504);

      // R11 TX FIFO full: 18 writes, first goes to shifter, 16 queued, last dropped
      for (int i = 0; i < 18; i++) bus_write(4'h0, 32'(8'h80 + i));
      bus_read(4'h4, s);
      chk(s[0] == 1'b1, "R11 full flag", s[0], 1);
      for (int i = 0; i < 17; i++) begin
         wait_rx(got);
         bus_read(4'h0, d);
         chk(got && d[7:0] == 8'(8'h80 + i), "R11 queued byte", d, 8'h80 + i);
      end
      repeat (600) @(negedge clk);
      bus_read(4'h4, s);
      chk(s[1:0] == 2'b00, "R11 dropped write", s[1:0], 0);

      // R12 + R10: RX full while every frame is bad; count saturates
      cfg_inject_tx = 1'b1;
      len = perr_seen;
      for (int i = 0; i < 256; i++) begin
         for (int k = 0; k < 3000; k++) begin
            bus_read(4'h4, s);
            if (!s[0]) break;
         end
         bus_write(4'h0, 32'(i));
      end
      repeat (17 * 176 + 400) @(negedge clk);
      cfg_inject_tx = 1'b0;
      bus_read(4'h4, s);
      chk(s[15:8] == 8'hFF, "R10 saturated", s[15:8], 8'hFF);
      chk(perr_seen - len == 256, "R12 R9 every dropped frame checked", perr_seen - len, 256);
      for (int i = 0; i < 16; i++) begin
         bus_read(4'h0, d);
         chk(d[7:0] == 8'(i), "R12 kept byte", d, i);
      end
      bus_read(4'h4, s);
      chk(s[1] == 1'b0 && s[2] == 1'b1, "R12 R9 rx empty sticky", s[2:1], 2'b10);

      summary();
      $finish;
   end
endmodule